// File: doc/BRIEF.md
# Memory Type Range Lookup Unit

This unit answers one question for the cache hierarchy: which memory type applies to a physical address range. Software loads a configuration store through a single write port. The store holds 88 per-region type bytes for the first megabyte, a set of variable ranges, each a base/mask pair, a global word and an upper-memory limit register. The global word carries the default type, a flag that says the first-megabyte table is present, and two enable bits.

A lookup presents a start address and an exclusive end address. The unit turns the end into an inclusive one, checks every variable range in parallel, and reduces the hits with a fixed precedence. It returns a registered 8-bit type one cycle after the request. There are two reserved codes: 0xFF means the lookup is switched off or was never configured, and 0xFE means the range is only partly covered by some valid variable range. Type codes are uncacheable 0x00, write-combining 0x01, write-through 0x04, write-protect 0x05 and write-back 0x06.

Top module: `memtype_lookup`

## Requirements
- R1: The result is 0xFF when no global word has been written since reset, or when global bits 9 and 10 are both clear.
- R2: When global bit 8 is set and start < 0x100000, the result is table byte k, chosen by start alone, ahead of every variable range. k = start>>16 below 0x80000; k = 8 + ((start-0x80000)>>14) below 0xC0000; k = 24 + ((start-0xC0000)>>12) otherwise.
- R3: Outside that table, when global bit 10 (variable enable) is clear, the result is the default type in global bits [7:0].
- R4: A variable range counts only while bit 11 of its mask word is set. It hits an address when (addr & mask) equals (base & mask), with bits [11:0] of the mask taken as zero.
- R5: If any valid range hits start but not the inclusive end, or the inclusive end but not start, the result is 0xFE. This outcome ranks ahead of R6 to R8.
- R6: Ranges that hit both ends resolve as follows. Two or more hits that include type 0x00 give 0x00. A mix of only 0x06 and 0x04 gives 0x04. Any other mix of unequal types gives 0x00. Equal types give that type.
- R7: When the limit register is non-zero, start >= 2^32 and the inclusive end < limit, the result is 0x06. This applies only when R5 and the conflicts of R6 did not decide the result.
- R8: With no hit, the result is the default type. With hits and no conflict, the result is the resolved type taken from base word bits [7:0].
- R9: req_end is exclusive; the inclusive end used by R5 and R7 is req_end - 1.
- R10: rsp_valid is req_valid delayed by one cycle, and rsp_type holds that request's result. A lookup in the same cycle as a configuration write sees the configuration from before the write.
- R11: Configuration writes use cfg_sel: 0 sets table byte cfg_idx (0 to 87) from cfg_wdata[7:0]; 1 sets base word cfg_idx; 2 sets mask word cfg_idx; 3 sets the global word; 4 sets the limit. Reset clears the whole store, marks it unloaded and drops rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target selector |
| cfg_idx | input | 7 | Table byte or variable range index |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Lookup request strobe |
| req_start | input | ADDR_W | First byte address of the range |
| req_end | input | ADDR_W | Address one past the last byte |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_type | output | 8 | Memory type or reserved code |

## Verification
A configuration write and a lookup can land on the same clock edge. The bench provokes this by rewriting the global default while it issues a lookup to an unmapped address below 4 GiB. The result of that lookup must still carry the old default, and the lookup one cycle later must carry the new one. Precedence is exercised in the same spirit: one range is made both partly covered and under the upper-memory window, and a second pair is made both conflicting and under that window, to confirm which outcome wins.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

    localparam int FIXED_CNT = 88;
    localparam int IDX_W     = 7;
    localparam int PAGE_BITS = 12;

    localparam logic [7:0] MT_UC      = 8'h00;
    localparam logic [7:0] MT_WC      = 8'h01;
    localparam logic [7:0] MT_WT      = 8'h04;
    localparam logic [7:0] MT_WP      = 8'h05;
    localparam logic [7:0] MT_WB      = 8'h06;
    localparam logic [7:0] MT_PARTIAL = 8'hFE;
    localparam logic [7:0] MT_OFF     = 8'hFF;

    typedef enum logic [2:0] {
        SEL_FIXED  = 3'd0,
        SEL_BASE   = 3'd1,
        SEL_MASK   = 3'd2,
        SEL_GLOBAL = 3'd3,
        SEL_LIMIT  = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic [7:0] def_type;
        logic       table_present;
        logic       en_global;
        logic       en_var;
    } glob_cfg_t;

    // page = address bits [19:12] of an address below 1 MiB
    function automatic logic [IDX_W-1:0] table_index(input logic [7:0] page);
        logic [IDX_W-1:0] k;
        if (!page[7])
            k = IDX_W'(page[6:4]);
        else if (!page[6])
            k = IDX_W'(8) + IDX_W'(page[5:2]);
        else
            k = IDX_W'(24) + IDX_W'(page[5:0]);
        return k;
    endfunction

endpackage

// File: rtl/memtype_cfg_store.sv
module memtype_cfg_store
    import memtype_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int NUM_VAR = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cfg_we,
    input  logic [2:0]                           cfg_sel,
    input  logic [IDX_W-1:0]                     cfg_idx,
    input  logic [ADDR_W-1:0]                    cfg_wdata,
    output logic [FIXED_CNT-1:0][7:0]            table_q,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]       base_q,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]       mask_q,
    output glob_cfg_t                            glob_q,
    output logic [ADDR_W-1:0]                    limit_q,
    output logic                                 loaded_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            table_q  <= '0;
            base_q   <= '0;
            mask_q   <= '0;
            glob_q   <= '0;
            limit_q  <= '0;
            loaded_q <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_FIXED: begin
                    for (int k = 0; k < FIXED_CNT; k++)
                        if (cfg_idx == IDX_W'(k)) table_q[k] <= cfg_wdata[7:0];
                end
                SEL_BASE: begin
                    for (int v = 0; v < NUM_VAR; v++)
                        if (cfg_idx == IDX_W'(v)) base_q[v] <= cfg_wdata;
                end
                SEL_MASK: begin
                    for (int v = 0; v < NUM_VAR; v++)
                        if (cfg_idx == IDX_W'(v)) mask_q[v] <= cfg_wdata;
                end
                SEL_GLOBAL: begin
                    glob_q.def_type      <= cfg_wdata[7:0];
                    glob_q.table_present <= cfg_wdata[8];
                    glob_q.en_global     <= cfg_wdata[9];
                    glob_q.en_var        <= cfg_wdata[10];
                    loaded_q             <= 1'b1;
                end
                SEL_LIMIT: limit_q <= cfg_wdata;
                default: ;
            endcase
        end
    end

    assert_global_marks_loaded_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == SEL_GLOBAL) |=> loaded_q);

    assert_limit_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_sel == SEL_LIMIT) |=> $stable(limit_q));

endmodule

// File: rtl/memtype_var_match.sv
module memtype_var_match
    import memtype_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] base_word,
    input  logic [ADDR_W-1:0] mask_word,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic              active,
    output logic              hit_first,
    output logic              hit_last,
    output logic [7:0]        range_type
);

    localparam logic [ADDR_W-1:0] PAGE_MASK = ~(ADDR_W'((64'd1 << PAGE_BITS) - 1));

    logic [ADDR_W-1:0] cmp_mask;
    logic [ADDR_W-1:0] tag;

    always_comb begin
        cmp_mask   = mask_word & PAGE_MASK;
        tag        = base_word & cmp_mask;
        active     = mask_word[11];
        hit_first  = (first_addr & cmp_mask) == tag;
        hit_last   = (last_addr  & cmp_mask) == tag;
        range_type = base_word[7:0];
    end

endmodule

// File: rtl/memtype_resolve.sv
module memtype_resolve
    import memtype_pkg::*;
#(
    parameter int NUM_VAR = 4
) (
    input  logic [NUM_VAR-1:0]      hit,
    input  logic [NUM_VAR-1:0][7:0] types,
    output logic                    any_hit,
    output logic                    conflict,
    output logic [7:0]              res_type
);

    localparam int CNT_W = $clog2(NUM_VAR + 1);

    logic             any_uc, has_wb, has_wt, uniform, found;
    logic [CNT_W-1:0] hits;
    logic [7:0]       lead;
    logic [NUM_VAR-1:0][7:0] norm;

    always_comb begin
        any_uc = 1'b0;
        has_wb = 1'b0;
        has_wt = 1'b0;
        for (int v = 0; v < NUM_VAR; v++) begin
            if (hit[v] && types[v] == MT_UC) any_uc = 1'b1;
            if (hit[v] && types[v] == MT_WB) has_wb = 1'b1;
            if (hit[v] && types[v] == MT_WT) has_wt = 1'b1;
        end
        for (int v = 0; v < NUM_VAR; v++)
            norm[v] = (has_wb && has_wt && types[v] == MT_WB) ? MT_WT : types[v];
        lead  = MT_UC;
        found = 1'b0;
        for (int v = 0; v < NUM_VAR; v++) begin
            if (hit[v] && !found) begin
                lead  = norm[v];
                found = 1'b1;
            end
        end
        uniform = 1'b1;
        for (int v = 0; v < NUM_VAR; v++)
            if (hit[v] && norm[v] != lead) uniform = 1'b0;
        hits     = CNT_W'($countones(hit));
        any_hit  = found;
        conflict = (hits > CNT_W'(1)) && (any_uc || !uniform);
        res_type = conflict ? MT_UC : lead;
    end

endmodule

// File: rtl/memtype_lookup.sv
module memtype_lookup
    import memtype_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int NUM_VAR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [6:0]        cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic              rsp_valid,
    output logic [7:0]        rsp_type
);

    logic [FIXED_CNT-1:0][7:0]      table_q;
    logic [NUM_VAR-1:0][ADDR_W-1:0] base_q, mask_q;
    glob_cfg_t                      glob_q;
    logic [ADDR_W-1:0]              limit_q;
    logic                           loaded_q;

    memtype_cfg_store #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) store_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .table_q(table_q),
        .base_q(base_q), .mask_q(mask_q), .glob_q(glob_q),
        .limit_q(limit_q), .loaded_q(loaded_q)
    );

    logic [ADDR_W-1:0]         last_addr;
    logic [NUM_VAR-1:0]        active, hit_f, hit_l;
    logic [NUM_VAR-1:0][7:0]   rtypes;

    assign last_addr = req_end - ADDR_W'(1);

    for (genvar v = 0; v < NUM_VAR; v++) begin : g_range
        memtype_var_match #(.ADDR_W(ADDR_W)) match_i (
            .base_word(base_q[v]), .mask_word(mask_q[v]),
            .first_addr(req_start), .last_addr(last_addr),
            .active(active[v]), .hit_first(hit_f[v]), .hit_last(hit_l[v]),
            .range_type(rtypes[v])
        );
    end

    logic       partial, any_hit, conflict, in_low_mb, above_4g, under_limit;
    logic [7:0] res_type, next_type;

    memtype_resolve #(.NUM_VAR(NUM_VAR)) resolve_i (
        .hit(active & hit_f), .types(rtypes),
        .any_hit(any_hit), .conflict(conflict), .res_type(res_type)
    );

    always_comb begin
        partial     = |(active & (hit_f ^ hit_l));
        in_low_mb   = req_start[ADDR_W-1:20] == '0;
        above_4g    = |req_start[ADDR_W-1:32];
        under_limit = (limit_q != '0) && above_4g && (last_addr < limit_q);
        if (!loaded_q || !(glob_q.en_global || glob_q.en_var))
            next_type = MT_OFF;
        else if (glob_q.table_present && in_low_mb)
            next_type = table_q[table_index(req_start[19:12])];
        else if (!glob_q.en_var)
            next_type = glob_q.def_type;
        else if (partial)
            next_type = MT_PARTIAL;
        else if (conflict)
            next_type = MT_UC;
        else if (under_limit)
            next_type = MT_WB;
        else if (any_hit)
            next_type = res_type;
        else
            next_type = glob_q.def_type;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_type  <= 8'h00;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) rsp_type <= next_type;
        end
    end

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_unloaded_is_off_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !loaded_q) |=> rsp_type == MT_OFF);

    assert_partial_needs_var_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && loaded_q && glob_q.en_var && partial && !(glob_q.table_present && in_low_mb))
        |=> rsp_type == MT_PARTIAL);

endmodule

// File: tb/memtype_lookup_tb_top.sv
module memtype_lookup_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [6:0]    cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_end = '0;
    logic          rsp_valid;
    logic [7:0]    rsp_type;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    memtype_lookup #(.ADDR_W(AW), .NUM_VAR(4)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_start(req_start), .req_end(req_end),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type)
    );

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10: response without request, actual %02h expected none", rsp_type);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rsp_type !== e) begin
                    fails++;
                    $display("FAIL %s: actual %02h expected %02h", t, rsp_type, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL R10: watchdog expired, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] sel, input int idx, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 7'(idx); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] s, input logic [AW-1:0] e,
                        input logic [7:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_start = s; req_end = e;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wr_and_look(input logic [2:0] sel, input logic [AW-1:0] d,
                               input logic [AW-1:0] s, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = '0; cfg_wdata = d;
        req_valid = 1'b1; req_start = s; req_end = s + 40'h1000;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        cfg_we = 1'b0; req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11: rsp_valid after reset, actual %0b expected 0", rsp_valid);
        end
    endtask

    initial begin
        do_reset();
        look(40'h30000, 40'h31000, 8'hFF, "R1 never loaded");
        wr(3'd0, 3,  40'h04);
        wr(3'd0, 13, 40'h01);
        wr(3'd0, 71, 40'h05);
        wr(3'd0, 87, 40'h06);
        look(40'h30000, 40'h31000, 8'hFF, "R1 table written, global not");
        wr(3'd3, 0, 40'h100);
        look(40'h30000, 40'h31000, 8'hFF, "R1 both enables clear");
        wr(3'd3, 0, 40'h306);
        look(40'h30000, 40'h31000, 8'h04, "R2 64K region 3");
        look(40'h94000, 40'h95000, 8'h01, "R2 16K region 13");
        look(40'hEF000, 40'hF0000, 8'h05, "R2 4K region 71");
        look(40'hFF000, 40'h100000, 8'h06, "R2 4K region 87");
        look(40'h80000, 40'h81000, 8'h00, "R2 16K region 8 unwritten");
        // variable ranges
        wr(3'd1, 0, 40'h1_0000_0006);  wr(3'd2, 0, 40'hFF_C000_0800);
        wr(3'd1, 1, 40'h1_0000_0004);  wr(3'd2, 1, 40'hFF_F000_0000);
        wr(3'd1, 2, 40'h2_0000_0001);  wr(3'd2, 2, 40'hFF_FF00_0800);
        wr(3'd1, 3, 40'h2_0000_0000);  wr(3'd2, 3, 40'hFF_FFC0_0000);
        wr(3'd3, 0, 40'h305);
        look(40'h1_2000_0000, 40'h1_2000_1000, 8'h05, "R3 variable enable clear");
        wr(3'd3, 0, 40'h705);
        look(40'h1_2000_0000, 40'h1_2000_1000, 8'h06, "R8 single hit");
        look(40'h1_0000_0000, 40'h1_0000_1000, 8'h06, "R4 invalid range ignored");
        wr(3'd2, 1, 40'hFF_F000_0800);
        look(40'h1_0000_0000, 40'h1_0000_1000, 8'h04, "R6 WB with WT");
        look(40'h1_0FFF_F000, 40'h1_1000_1000, 8'hFE, "R5 partial cover");
        look(40'h1_0FFF_F000, 40'h1_1000_0000, 8'h04, "R9 exclusive end");
        look(40'h2_0080_0000, 40'h2_0080_1000, 8'h01, "R8 WC hit");
        wr(3'd2, 3, 40'hFF_FFC0_0800);
        look(40'h2_0000_0000, 40'h2_0000_1000, 8'h00, "R6 UC wins");
        wr(3'd1, 3, 40'h2_0000_0006);
        look(40'h2_0000_0000, 40'h2_0000_1000, 8'h00, "R6 WC with WB");
        look(40'h3_0000_0000, 40'h3_0000_1000, 8'h05, "R8 no hit default");
        look(40'h30000, 40'h31000, 8'h04, "R2 table over variable");
        wr(3'd4, 0, 40'h4_0000_0000);
        look(40'h3_0000_0000, 40'h3_0000_1000, 8'h06, "R7 limit no hit");
        look(40'h2_0080_0000, 40'h2_0080_1000, 8'h06, "R7 limit over single hit");
        look(40'h2_0000_0000, 40'h2_0000_1000, 8'h00, "R7 conflict beats limit");
        look(40'h1_0FFF_F000, 40'h1_1000_1000, 8'hFE, "R7 partial beats limit");
        look(40'h3_FFFF_F000, 40'h4_0000_1000, 8'h05, "R7 end above limit");
        look(40'h9000_0000, 40'h9000_1000, 8'h05, "R7 start below 4G");
        wr_and_look(3'd3, 40'h702, 40'h9000_0000, 8'h05, "R10 same-cycle write unseen");
        look(40'h9000_0000, 40'h9000_1000, 8'h02, "R10 write seen next");
        wr(3'd3, 0, 40'h002);
        look(40'h9000_0000, 40'h9000_1000, 8'hFF, "R1 enables cleared");
        repeat (3) @(negedge clk);
        do_reset();
        look(40'h30000, 40'h31000, 8'hFF, "R11 reset unloads store");
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10: missing responses, actual %0d pending expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule